// File: doc/BRIEF.md
# Multichannel Serial ADC Scan Controller

This block is the host side of a serial link to an eight-input, 12-bit converter whose conversion clock is the serial clock. It makes an active-low chip select and a serial clock from the system clock through a divider set at run time. In every frame it sends a 16-bit command on `mosi` and collects a 16-bit reply from `miso`. The reply is four leading zero bits followed by a 12-bit straight-binary code, most significant bit first. The controller removes the leading bits and presents the code, tagged with its channel, in a one-entry output register with a valid/ready handshake.

A single frame selects the channel for the next conversion and also returns the code for the channel chosen one frame earlier. The controller therefore keeps the channel one frame behind. It drops the first reply after reset and after every switch between single-channel and scan operation. It either converts one fixed channel again and again, or it steps through the channels that are set in an enable mask. Frames stop while the output register is full. The command bits other than the channel field come unchanged from a static configuration input.

Top module: `adc_scan_master`

## Requirements
- R1: While reset is active and directly after it, `cs_n` is high, `sclk` is high and `res_valid` is low.
- R2: While `cs_n` is low, `sclk` makes exactly 16 rising edges. Each high phase and each low phase lasts `div_half` system clocks (a value of 0 counts as 1). `sclk` is high whenever `cs_n` is high.
- R3: The command is shifted out on `mosi` MSB first and changes only at the chip-select falling edge or on `sclk` falling edges. Bits [ADDR_LSB+2:ADDR_LSB] (default ADDR_LSB = 10) carry the channel. Every other bit equals the matching bit of `cfg_word`.
- R4: `miso` is sampled on `sclk` rising edges, MSB first. `res_data` is the low 12 bits of the 16-bit reply.
- R5: `res_err` is 1 exactly when any of the four leading reply bits is 1. The code is still delivered.
- R6: `res_ch` is the channel that was commanded in the frame before the one that returned the code. A result appears in the same cycle that `cs_n` rises.
- R7: The reply of the first frame after reset, and of the first frame after `scan_mode` changes, is not delivered.
- R8: With `scan_mode` = 0, every frame commands `single_ch`.
- R9: With `scan_mode` = 1, frames command the channels whose `ch_mask` bit is 1, in ascending order with wrap-around. An all-zero mask starts no frame.
- R10: While `res_valid` is high and `res_ready` is low, the result outputs stay unchanged. No frame starts while `res_valid` is high.
- R11: Between the rise of `cs_n` and the next fall, `cs_n` stays high for at least two `div_half` periods, which is one full SCLK period.
- R12: While `enable` is low, no new frame starts. A frame already in progress runs to its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to start |
| scan_mode | input | 1 | 0: one fixed channel, 1: step through the mask |
| single_ch | input | CHW | Channel used when scan_mode is 0 |
| ch_mask | input | NCH | Channels visited when scan_mode is 1 |
| cfg_word | input | FRAME_BITS | Static command bits outside the channel field |
| div_half | input | DIVW | System clocks per SCLK half period |
| sclk | output | 1 | Serial clock to the converter, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Reply data from the converter |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | RESW | 12-bit conversion code |
| res_ch | output | CHW | Channel that the code belongs to |
| res_err | output | 1 | A leading reply bit was nonzero |

## Verification
The bound checker watches the serial signalling on every cycle. It checks that the clock is high whenever chip select is high, that `mosi` is steady at each rising edge, that the gap between frames is long enough, that frames only begin while results may be accepted and enable was set, and that a held result does not move. Other properties need a model of the converter in the bench and can only be shown in its scenarios: the value of the command field, the exact SCLK phase lengths and edge count, the one-frame-late channel tag, the dropped first reply, the scan order over different masks, and the error flag on injected leading bits.

// File: rtl/adc_scan_master.sv
module adc_scan_master #(
  parameter int NCH        = 8,
  parameter int CHW        = $clog2(NCH),
  parameter int FRAME_BITS = 16,
  parameter int RESW       = 12,
  parameter int ADDR_LSB   = 10,
  parameter int DIVW       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  scan_mode,
  input  logic [CHW-1:0]        single_ch,
  input  logic [NCH-1:0]        ch_mask,
  input  logic [FRAME_BITS-1:0] cfg_word,
  input  logic [DIVW-1:0]       div_half,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [RESW-1:0]       res_data,
  output logic [CHW-1:0]        res_ch,
  output logic                  res_err
);
  localparam int HALVES = 2 * FRAME_BITS;
  localparam int LAST   = HALVES + 2;
  localparam int HW     = $clog2(LAST + 1);

  logic                  busy, primed, mode_q, drop;
  logic [HW-1:0]         hcnt;
  logic [DIVW-1:0]       dcnt;
  logic [FRAME_BITS-1:0] shreg, rx, cmd;
  logic [CHW-1:0]        last_ch, frame_ch, prev_ch, scan_next, next_ch;
  logic                  found, have_ch, start, tick;
  logic [DIVW-1:0]       div_eff;

  assign div_eff = (div_half == '0) ? DIVW'(1) : div_half;
  assign tick    = busy && (dcnt >= div_eff - DIVW'(1));
  assign mosi    = shreg[FRAME_BITS-1];
  assign next_ch = scan_mode ? scan_next : single_ch;
  assign have_ch = scan_mode ? |ch_mask : 1'b1;
  assign start   = !busy && enable && !res_valid && have_ch;

  always_comb begin
    logic [CHW-1:0] idx;
    scan_next = last_ch;
    found     = 1'b0;
    for (int i = 1; i <= NCH; i++) begin
      idx = last_ch + CHW'(i);
      if (!found && ch_mask[idx]) begin
        scan_next = idx;
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    cmd = cfg_word & ~(FRAME_BITS'({CHW{1'b1}}) << ADDR_LSB);
    cmd = cmd | (FRAME_BITS'(next_ch) << ADDR_LSB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      primed    <= 1'b0;
      mode_q    <= 1'b0;
      drop      <= 1'b1;
      hcnt      <= '0;
      dcnt      <= '0;
      shreg     <= '0;
      rx        <= '0;
      last_ch   <= '0;
      frame_ch  <= '0;
      prev_ch   <= '0;
      sclk      <= 1'b1;
      cs_n      <= 1'b1;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ch    <= '0;
      res_err   <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        cs_n     <= 1'b0;
        sclk     <= 1'b1;
        shreg    <= cmd;
        hcnt     <= '0;
        dcnt     <= '0;
        frame_ch <= next_ch;
        last_ch  <= next_ch;
        drop     <= !primed || (scan_mode != mode_q);
        mode_q   <= scan_mode;
        primed   <= 1'b1;
      end else if (busy) begin
        dcnt <= tick ? '0 : dcnt + DIVW'(1);
        if (tick) begin
          hcnt <= hcnt + HW'(1);
          if (hcnt < HW'(HALVES)) begin
            sclk <= ~sclk;
            if (hcnt[0]) rx <= {rx[FRAME_BITS-2:0], miso};
            else if (hcnt != '0) shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
          end
          if (hcnt == HW'(HALVES)) begin
            cs_n    <= 1'b1;
            prev_ch <= frame_ch;
            if (!drop) begin
              res_valid <= 1'b1;
              res_data  <= rx[RESW-1:0];
              res_err   <= |rx[FRAME_BITS-1:RESW];
              res_ch    <= prev_ch;
            end
          end
          if (hcnt == HW'(LAST)) busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_master_chk.sv
module adc_scan_master_chk #(
  parameter int CHW  = 3,
  parameter int RESW = 12,
  parameter int DIVW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            sclk,
  input logic            cs_n,
  input logic            mosi,
  input logic            res_valid,
  input logic            res_ready,
  input logic [RESW-1:0] res_data,
  input logic [CHW-1:0]  res_ch,
  input logic            res_err,
  input logic [DIVW-1:0] div_half
);
  logic [DIVW+1:0] gap;
  logic [DIVW+1:0] need;
  assign need = (div_half == '0) ? (DIVW+2)'(2) : {1'b0, div_half, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '1;
    else if (!cs_n) gap <= '0;
    else if (gap != '1) gap <= gap + 1'b1;
  end

  p_sclk_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  p_result_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $rose(cs_n));
  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_ch) && $stable(res_err)));
  p_no_start_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !res_valid);
  p_frame_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gap >= need));
  p_start_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(enable));
endmodule

bind adc_scan_master adc_scan_master_chk #(.CHW(CHW), .RESW(RESW), .DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_ch(res_ch),
  .res_err(res_err), .div_half(div_half)
);

// File: tb/adc_scan_master_tb.sv
`timescale 1ns/1ps
module adc_scan_master_tb;
  localparam int ADDR_LSB = 10;
  localparam logic [15:0] CFG = 16'hA1C3;
  localparam logic [15:0] FMASK = 16'(7) << ADDR_LSB;
  // {scan_mode, single_ch, ch_mask, div_half}
  localparam logic [19:0] VEC [0:5] = '{
    {1'b0, 3'd3, 8'h00, 8'd2},
    {1'b0, 3'd0, 8'h00, 8'd1},
    {1'b1, 3'd0, 8'hA5, 8'd2},
    {1'b1, 3'd0, 8'h80, 8'd3},
    {1'b1, 3'd0, 8'hFF, 8'd0},
    {1'b0, 3'd7, 8'h00, 8'd2}
  };

  logic clk = 0, rst_n = 0, enable = 0, scan_mode = 0, res_ready = 0;
  logic [2:0] single_ch = 0;
  logic [7:0] ch_mask = 0, div_half = 8'd2;
  logic sclk, cs_n, mosi, miso, res_valid, res_err;
  logic [11:0] res_data;
  logic [2:0] res_ch;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  adc_scan_master u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scan_mode(scan_mode),
    .single_ch(single_ch), .ch_mask(ch_mask), .cfg_word(CFG), .div_half(div_half),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_ch(res_ch), .res_err(res_err)
  );

  function automatic logic [11:0] code(input logic [2:0] c);
    return 12'(int'(c) * 409 + 37);
  endfunction

  function automatic logic [2:0] next_en(input logic [7:0] m, input logic [2:0] p);
    for (int i = 1; i <= 8; i++) if (m[3'(int'(p) + i)]) return 3'(int'(p) + i);
    return p;
  endfunction

  // converter model
  logic inj_err = 0, seen = 0, tx_err = 0, done_err = 0;
  logic [15:0] tx = 0, rxcmd = 0;
  logic [2:0] cur_ch = 3'd7, tx_ch = 0, done_ch = 0;
  int fcnt = 0, rcnt = 0, frames = 0, falls = 0, bad_edges = 0, bad_cmd = 0, bad_half = 0;

  always @(negedge cs_n) begin
    seen = 1; falls++; fcnt = 0; rcnt = 0;
    tx_ch = cur_ch; tx_err = inj_err;
    tx = {inj_err ? 4'h9 : 4'h0, code(cur_ch)};
  end
  always @(negedge sclk) if (cs_n === 1'b0) fcnt++;
  always @(posedge sclk) if (cs_n === 1'b0) begin rxcmd = {rxcmd[14:0], mosi}; rcnt++; end
  always @(posedge cs_n) if (seen) begin
    frames++;
    if (rcnt != 16) bad_edges++;
    if ((rxcmd & ~FMASK) != (CFG & ~FMASK)) bad_cmd++;
    cur_ch = rxcmd[ADDR_LSB +: 3];
    done_ch = tx_ch; done_err = tx_err;
  end
  always_comb begin
    int b;
    b = (fcnt == 0) ? 0 : ((fcnt > 16) ? 15 : fcnt - 1);
    miso = cs_n ? 1'b0 : tx[4'(15 - b)];
  end

  logic sp = 1, pcs = 1;
  int run = 0;
  always @(negedge clk) begin
    if (!cs_n) begin
      if (pcs) run = 1;
      else if (sclk != sp) begin
        if (run != ((div_half == 0) ? 1 : int'(div_half))) bad_half++;
        run = 1;
      end else run++;
    end
    sp = sclk; pcs = cs_n;
  end

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  logic [2:0] got_ch;
  logic [11:0] got_data;
  logic got_err;

  task automatic get_result();
    do @(negedge clk); while (!res_valid);
    got_ch = res_ch; got_data = res_data; got_err = res_err;
    chk(res_ch == done_ch, "R6 channel tag", res_ch, done_ch);
    chk(res_data == code(done_ch), "R4 result code", res_data, code(done_ch));
    chk(res_err == done_err, "R5 error flag", res_err, done_err);
    res_ready = 1; @(negedge clk); res_ready = 0;
  endtask

  task automatic quiesce();
    enable = 0;
    repeat (300) @(negedge clk);
    if (res_valid) begin res_ready = 1; @(negedge clk); res_ready = 0; end
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic pmode;
    logic [2:0] pch;
    int base;
    repeat (5) @(negedge clk);
    chk(cs_n == 1 && sclk == 1 && res_valid == 0, "R1 reset state", {cs_n, sclk, res_valid}, 3'b110);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 1 && res_valid == 0, "R1 after release", {cs_n, sclk, res_valid}, 3'b110);

    single_ch = 3'd5; enable = 1;
    get_result();
    chk(frames == 2, "R7 first reply dropped", frames, 2);
    chk(got_ch == 3'd5, "R8 single channel", got_ch, 5);
    pmode = 0;

    for (int v = 0; v < 6; v++) begin
      quiesce();
      scan_mode = VEC[v][19]; single_ch = VEC[v][18:16];
      ch_mask = VEC[v][15:8]; div_half = VEC[v][7:0];
      base = (scan_mode == pmode) ? 1 : 0;
      pmode = scan_mode;
      enable = 1;
      for (int k = 0; k < 5; k++) begin
        get_result();
        if (k >= base) begin
          if (!scan_mode) chk(got_ch == single_ch, "R8 single channel", got_ch, single_ch);
          else begin
            chk(ch_mask[got_ch], "R9 channel enabled", got_ch, ch_mask);
            if (k > base) chk(got_ch == next_en(ch_mask, pch), "R9 scan order", got_ch, next_en(ch_mask, pch));
          end
        end
        pch = got_ch;
      end
    end

    // R5: injected leading bits
    inj_err = 1;
    get_result();
    get_result();
    chk(got_err == 1, "R5 error on nonzero lead", got_err, 1);
    chk(got_data == code(got_ch), "R5 code kept with error", got_data, code(got_ch));
    inj_err = 0;

    // R10: stall while full
    do @(negedge clk); while (!res_valid);
    got_data = res_data; base = falls;
    repeat (300) @(negedge clk);
    chk(falls == base, "R10 no frame while full", falls - base, 0);
    chk(res_valid && res_data == got_data, "R10 result held", res_data, got_data);
    res_ready = 1; @(negedge clk); res_ready = 0;

    // R12: enable low
    quiesce();
    base = falls;
    repeat (300) @(negedge clk);
    chk(falls == base, "R12 no frame when disabled", falls - base, 0);

    // R9: empty mask
    scan_mode = 1; ch_mask = 8'h00; enable = 1;
    base = falls;
    repeat (300) @(negedge clk);
    chk(falls == base, "R9 empty mask idles", falls - base, 0);
    enable = 0;

    chk(frames > 30, "R2 frames observed", frames, 31);
    chk(bad_edges == 0, "R2 sixteen rising edges per frame", bad_edges, 0);
    chk(bad_half == 0, "R2 half period length", bad_half, 0);
    chk(bad_cmd == 0, "R3 fixed command bits", bad_cmd, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule